// File: doc/BRIEF.md
# 10 Mb/s Manchester Transmit Serializer

This block turns 4-bit transmit nibbles into a single Manchester-coded line bit for a 10 Mb/s twisted-pair transmitter. It runs on the 20 MHz half-bit clock. A free-running phase counter divides that clock by eight. The counter marks the one cycle in eight where the nibble and its enable are sampled, which is the 2.5 MHz nibble rate. Every sampled nibble is shifted out least significant bit first. Each bit is sent as two half-bit cells.

When the enable is found low at a sample point after data has been sent, the block appends a start-of-idle pulse. The line is held high for two bit times, and then drive-enable is released. The downstream shaping filter and line driver see a digital bit plus a drive-enable. While drive-enable is low, the bit rests low.

Top module: `manchester_tx`

## Requirements
- R1: `nib_take_o` is high for exactly one cycle in every 8. The first pulse comes in the 8th cycle after reset is released, and the pulses repeat every 8 cycles regardless of traffic.
- R2: `txd_i` and `tx_en_i` are sampled only at the rising clock edge that ends a cycle with `nib_take_o` high. Their values in all other cycles have no effect on `tx_o` or `tx_oe_o`.
- R3: Each data bit occupies two consecutive cycles. The first cycle carries the complement of the bit and the second carries the bit, so a 1 is sent as low then high.
- R4: A sampled nibble is sent in the 8 cycles that immediately follow its sample edge, with bit 0 first and bit 3 last.
- R5: A packet starts when `tx_en_i` is high at a sample edge while the line is idle. `tx_oe_o` rises in the next cycle.
- R6: When `tx_en_i` is low at a sample edge after a data nibble, `tx_o` and `tx_oe_o` are both high for 4 cycles (two bit times). After that, `tx_oe_o` falls.
- R7: If `tx_en_i` falls between sample edges, the nibble currently being sent is finished in full before the start-of-idle pulse begins.
- R8: While idle and during reset, `tx_o` and `tx_oe_o` are 0.
- R9: A new packet can only start at a sample edge after the start-of-idle pulse has ended. A packet restarted at the first such edge follows the pulse with exactly 4 idle cycles.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | 20 MHz half-bit clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| txd_i | input | 4 | Transmit nibble |
| tx_en_i | input | 1 | Transmit enable, sampled with the nibble |
| nib_take_o | output | 1 | Marks the cycle whose closing edge samples the inputs |
| tx_o | output | 1 | Manchester line bit |
| tx_oe_o | output | 1 | Line drive-enable |

## Verification
The phase counter, frame state and shift register are the only registers on the path, and the line outputs are decoded from them without further delay. A nibble sampled at one edge therefore shows its first half-cell in the very next cycle. The start-of-idle pulse likewise begins in the cycle after a sample edge that finds the enable low. The bench model steps at each rising edge, queuing the 8 or 4 expected cells at sample edges. It compares `nib_take_o`, `tx_o` and `tx_oe_o` at every falling edge, half a period after the registers settle. Between sample points the bench drives noise on the nibble and enable inputs, so every compare also covers the sampling rule.

// File: rtl/mtx_pkg.sv
package mtx_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_DATA = 2'd1,
    ST_SOI  = 2'd2
  } tx_st_e;
endpackage

// File: rtl/mtx_phase.sv
module mtx_phase #(
  parameter int CELLS = 8,
  localparam int PH_W = $clog2(CELLS)
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  output logic [PH_W-1:0] ph_o,
  output logic            last_o
);
  localparam logic [PH_W-1:0] PH_LAST = PH_W'(CELLS - 1);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)            ph_o <= '0;
    else if (ph_o == PH_LAST) ph_o <= '0;
    else                    ph_o <= ph_o + 1'b1;
  end

  assign last_o = (ph_o == PH_LAST);

  a_r1_wrap: assert property (@(posedge clk_i) disable iff (!rst_ni)
    last_o |=> (ph_o == '0));
endmodule

// File: rtl/mtx_frame.sv
module mtx_frame
  import mtx_pkg::*;
#(
  parameter int NIB_W     = 4,
  parameter int SOI_CELLS = 4,
  localparam int CELLS = 2 * NIB_W,
  localparam int PH_W  = $clog2(CELLS)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             last_i,
  input  logic [PH_W-1:0]  ph_i,
  input  logic [NIB_W-1:0] txd_i,
  input  logic             tx_en_i,
  output tx_st_e           st_o,
  output logic             bit_o
);
  localparam logic [PH_W-1:0] SOI_END = PH_W'(SOI_CELLS - 1);

  tx_st_e           st_q, st_d;
  logic [NIB_W-1:0] sh_q;

  always_comb begin
    st_d = st_q;
    if (last_i) begin
      if (tx_en_i)             st_d = ST_DATA;
      else if (st_q == ST_DATA) st_d = ST_SOI;
      else                     st_d = ST_IDLE;
    end else if (st_q == ST_SOI && ph_i == SOI_END) begin
      st_d = ST_IDLE;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q <= ST_IDLE;
      sh_q <= '0;
    end else begin
      st_q <= st_d;
      if (last_i && tx_en_i) sh_q <= txd_i;
    end
  end

  // LSB first: bit index is the cell pair number
  assign bit_o = sh_q[ph_i[PH_W-1:1]];
  assign st_o  = st_q;

  a_r5_start: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == ST_IDLE && last_i && tx_en_i) |=> (st_q == ST_DATA));
  a_r6_soi_end: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == ST_SOI && ph_i == SOI_END) |=> (st_q == ST_IDLE));
  a_r7_hold_nibble: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == ST_DATA && !last_i) |=> (st_q == ST_DATA && $stable(sh_q)));
endmodule

// File: rtl/mtx_line.sv
module mtx_line
  import mtx_pkg::*;
(
  input  tx_st_e st_i,
  input  logic   bit_i,
  input  logic   half_i,
  output logic   tx_o,
  output logic   oe_o
);
  always_comb begin
    unique case (st_i)
      ST_DATA: begin tx_o = half_i ? bit_i : ~bit_i; oe_o = 1'b1; end
      ST_SOI:  begin tx_o = 1'b1;                    oe_o = 1'b1; end
      default: begin tx_o = 1'b0;                    oe_o = 1'b0; end
    endcase
  end
endmodule

// File: rtl/manchester_tx.sv
module manchester_tx
  import mtx_pkg::*;
#(
  parameter int NIB_W    = 4,
  parameter int SOI_BITS = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [NIB_W-1:0] txd_i,
  input  logic             tx_en_i,
  output logic             nib_take_o,
  output logic             tx_o,
  output logic             tx_oe_o
);
  localparam int CELLS     = 2 * NIB_W;
  localparam int PH_W      = $clog2(CELLS);
  localparam int SOI_CELLS = 2 * SOI_BITS;

  initial begin
    if (SOI_CELLS >= CELLS) $error("start-of-idle must be shorter than a nibble");
  end

  logic [PH_W-1:0] ph;
  logic            last;
  tx_st_e          st;
  logic            cur_bit;

  mtx_phase #(.CELLS(CELLS)) u_phase (
    .clk_i (clk_i), .rst_ni(rst_ni), .ph_o(ph), .last_o(last)
  );

  mtx_frame #(.NIB_W(NIB_W), .SOI_CELLS(SOI_CELLS)) u_frame (
    .clk_i (clk_i), .rst_ni(rst_ni), .last_i(last), .ph_i(ph),
    .txd_i (txd_i), .tx_en_i(tx_en_i), .st_o(st), .bit_o(cur_bit)
  );

  mtx_line u_line (
    .st_i(st), .bit_i(cur_bit), .half_i(ph[0]), .tx_o(tx_o), .oe_o(tx_oe_o)
  );

  assign nib_take_o = last;

  a_r1_take_gap: assert property (@(posedge clk_i) disable iff (!rst_ni)
    nib_take_o |=> !nib_take_o);
  a_r3_mid_flip: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st == ST_DATA && ph[0]) |-> (tx_o != $past(tx_o)));
  a_r8_idle_low: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !tx_oe_o |-> !tx_o);
  a_r6_release_high: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(tx_oe_o) |-> $past(tx_o));
  a_r5_rise_aligned: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(tx_oe_o) |-> (ph == '0));
endmodule

// File: tb/sim_manchester_tx.sv
module sim_manchester_tx;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [3:0] txd = 4'h0;
  logic       tx_en = 1'b0;
  logic       take, tx, oe;

  int n_chk = 0, n_fail = 0, cyc = 0;

  always #5 clk = ~clk;

  manchester_tx u0 (
    .clk_i(clk), .rst_ni(rst_n), .txd_i(txd), .tx_en_i(tx_en),
    .nib_take_o(take), .tx_o(tx), .tx_oe_o(oe)
  );

  // behavioural model: queue of expected (tx,oe) cells
  bit    q_tx[$];
  string q_tag[$];
  int    m_ph = 0;
  bit    m_send = 0;

  always @(posedge clk) begin
    cyc++;
    if (!rst_n) begin
      q_tx.delete(); q_tag.delete(); m_ph = 0; m_send = 0;
    end else begin
      if (q_tx.size() > 0) begin void'(q_tx.pop_front()); void'(q_tag.pop_front()); end
      if (m_ph == 7) begin
        if (tx_en) begin
          for (int b = 0; b < 4; b++) begin   // R4 LSB first, R3 ~b then b
            q_tx.push_back(~txd[b]); q_tag.push_back("R3/R4");
            q_tx.push_back(txd[b]);  q_tag.push_back("R3/R4");
          end
          m_send = 1;
        end else if (m_send) begin
          for (int c = 0; c < 4; c++) begin q_tx.push_back(1'b1); q_tag.push_back("R6"); end
          m_send = 0;
        end
      end
      m_ph = (m_ph + 1) % 8;
    end
  end

  task automatic chk(input string req, input logic act, input logic exp, input string what);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s actual=%0b expected=%0b t=%0t", req, what, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (!rst_n) begin
      chk("R8", tx, 1'b0, "tx in reset");
      chk("R8", oe, 1'b0, "oe in reset");
    end else begin
      chk("R1", take, (m_ph == 7), "nib_take");
      if (q_tx.size() > 0) begin
        chk(q_tag[0], tx, q_tx[0], "tx");
        chk({q_tag[0], " R5"}, oe, 1'b1, "oe");
      end else begin
        chk("R8/R9", tx, 1'b0, "idle tx");
        chk("R8/R9", oe, 1'b0, "idle oe");
      end
    end
  end

  // present d/en at the next sample cycle; noise elsewhere (R2, R7)
  task automatic nib(input logic [3:0] d, input logic en);
    @(negedge clk);
    while (!take) begin
      txd = 4'($urandom);
      tx_en = ~tx_en;
      @(negedge clk);
    end
    txd = d; tx_en = en;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    nib(4'h3, 1'b0);                           // idle, R2 noise
    nib(4'h0, 1'b1); nib(4'hF, 1'b1); nib(4'hA, 1'b1); nib(4'h5, 1'b1); // R5 R3 R4
    nib(4'h0, 1'b0);                           // R6 R7
    nib(4'h1, 1'b1); nib(4'h8, 1'b1);          // R9 restart at first edge
    nib(4'h0, 1'b0);
    nib(4'h0, 1'b0); nib(4'h0, 1'b0);          // R8 idle
    for (int i = 0; i < 40; i++) nib(4'($urandom), 1'b1);
    nib(4'h0, 1'b0);
    nib(4'hC, 1'b1); nib(4'h0, 1'b0);          // single-nibble packet
    repeat (3) nib(4'h0, 1'b0);
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    wait (cyc >= 100000);
    n_chk++; n_fail++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule